// File: doc/BRIEF.md
# Bus Wake-up Pattern Detector

This block is the digital part of a bus transceiver's standby path. It takes a bus-level input that an analog comparator has already reduced to one bit (1 = dominant, 0 = recessive). It also takes a standby flag and a wake-feature enable. It decides whether a remote node has asked the local system to wake up.

A wake-up request is accepted only when three events arrive in order inside one time window:

1. A long dominant phase.
2. A short-filtered recessive phase.
3. A second short-filtered dominant phase.

Requiring three events means a bus that is stuck dominant, whether from a short circuit or a faulty node, can never hold the system awake. The window timer keeps expiring and detection starts over.

The block tells the host controller about an accepted request on its receive line. In standby the receive output normally sits high. After acceptance it follows the bus: low while the bus is dominant, high while it is recessive. A one-cycle wake flag is also given for local logic. Outside standby the receive output simply follows the bus.

All filter and window lengths are elaboration parameters counted in clock cycles.

Top module: `bus_wake_detector`

## Requirements
- R1: With standby low, rxd_o equals the inverse of bus_dom_i, delayed by exactly three clock cycles: two synchronizer stages plus one output register.
- R2: In standby with no accepted wake-up, rxd_o stays 1 whatever the bus does.
- R3: The first event is complete once EV1_CYC consecutive synchronized samples are dominant. A dominant pulse shorter than this is discarded and does not advance the sequence.
- R4: After the first event, the second event is complete once EV23_CYC consecutive recessive samples are seen. A shorter recessive gap does not count.
- R5: After the second event, the third event is complete once EV23_CYC consecutive dominant samples are seen. Completing it is the only way a wake-up is accepted.
- R6: The sample that completes the third event must be no later than sample number WINDOW_CYC, counting the first dominant sample of the first event as sample 1. If the window runs out first, the sequence is dropped with no wake-up, and detection restarts from the first event.
- R7: On acceptance, wake_pulse_o is 1 for exactly one cycle. It rises in the same cycle the block enters its woken state.
- R8: Once a wake-up is accepted, rxd_o follows the inverse of the bus in standby, with the same three-cycle delay. This lasts until standby is left or reset is applied.
- R9: With wake_en_i low, no wake-up is ever accepted, and rxd_o stays 1 in standby.
- R10: Reset, or any cycle with standby low, clears the event sequence, the window timer and the woken state. After reset, rxd_o is 1 and wake_pulse_o is 0.
- R11: A bus held dominant indefinitely never produces a wake-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| standby_i | input | 1 | 1 while the transceiver is in low-power standby |
| wake_en_i | input | 1 | 1 enables remote wake-up detection |
| bus_dom_i | input | 1 | Asynchronous bus level from the comparator, 1 = dominant |
| rxd_o | output | 1 | Receive line to the host controller, 0 = dominant reported |
| wake_pulse_o | output | 1 | One-cycle flag when a wake-up request is accepted |

## Verification
The bench goes after the filter edges: runs of exactly the filter length, and runs one cycle short. A design that counted one cycle too few or too many would accept a pattern it should reject, or miss one it should accept.

It places the third event on the last legal sample of the window and then one sample later. An off-by-one window timer shows up as a wake-up flag that appears or disappears wrongly.

It holds the bus dominant for many windows, then releases it and sends a valid pattern. A design that treated a stuck bus as repeated events would flag a wake-up early. One that failed to restart after expiry would miss the later pattern.

It also checks that leaving standby or resetting drops the woken state. A design that kept that state would drive rxd_o low on a dominant bus where it must stay high.

// File: rtl/wake_pkg.sv
// Shared types for the bus wake-up pattern detector.
// Assumes: a single clock domain after the input synchronizer.
package wake_pkg;

    // Position in the three-event wake-up sequence.
    typedef enum logic [1:0] {
        SEQ_IDLE      = 2'd0,   // waiting for the long dominant phase
        SEQ_WAIT_REC  = 2'd1,   // first event done, waiting for recessive
        SEQ_WAIT_DOM3 = 2'd2,   // second event done, waiting for dominant
        SEQ_WOKEN     = 2'd3    // request accepted, receive line follows bus
    } seq_state_t;

    // Bus level coding used on every internal level signal.
    localparam logic LVL_DOMINANT  = 1'b1;
    localparam logic LVL_RECESSIVE = 1'b0;

endpackage

// File: rtl/wake_sync.sv
// Multi-stage synchronizer for the asynchronous bus level.
// Assumes: STAGES >= 1; reset value is the recessive level so a reset
// never presents a false dominant sample to the filters.
module wake_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    import wake_pkg::*;

    logic [STAGES-1:0] sr_q;

    generate
        if (STAGES == 1) begin : g_single
            // Purpose: single capture flop.
            always_ff @(posedge clk) begin
                if (!rst_n) sr_q <= {STAGES{LVL_RECESSIVE}};
                else        sr_q <= d_i;
            end
        end else begin : g_chain
            // Purpose: shift the bus level through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) sr_q <= {STAGES{LVL_RECESSIVE}};
                else        sr_q <= {sr_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = sr_q[STAGES-1];

endmodule

// File: rtl/wake_run_filter.sv
// Run-length filter: reports a hit on the sample that completes LEN
// consecutive samples equal to the target level. Any sample at the other
// level, or a clear, restarts the count. The count also restarts after a
// hit, so a following phase is measured from zero.
// Assumes: LEN >= 1; target may change only together with a hit or clear.
module wake_run_filter #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic level_i,
    input  logic target_i,
    output logic hit_o
);
    localparam int            CW   = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] run_q;
    logic          match;

    assign match = (level_i == target_i);
    assign hit_o = !clr_i && match && (run_q == LAST);

    // Purpose: count consecutive matching samples, restart on mismatch or hit.
    always_ff @(posedge clk) begin
        if (!rst_n)                 run_q <= '0;
        else if (clr_i || !match)   run_q <= '0;
        else if (run_q == LAST)     run_q <= '0;
        else                        run_q <= run_q + 1'b1;
    end

endmodule

// File: rtl/wake_window_timer.sv
// Saturating window timer. Counts cycles while inc_i is set and reports
// expiry once LIMIT cycles have elapsed since the first counted cycle.
// Assumes: LIMIT >= 1; clr_i takes priority over inc_i.
module wake_window_timer #(
    parameter int LIMIT = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic expired_o
);
    localparam int            TW  = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] TOP = TW'(LIMIT);

    logic [TW-1:0] cnt_q;

    assign expired_o = (cnt_q == TOP);

    // Purpose: advance the window count, hold at the limit, clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (clr_i)         cnt_q <= '0;
        else if (inc_i && !expired_o) cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/wake_seq_ctrl.sv
// Sequence controller for the three-event wake-up pattern. Steers the two
// run filters and the window timer, tracks the sequence state and raises
// a one-cycle flag when the third event completes inside the window.
// Assumes: EV1 filter length <= window length; expiry beats a completing
// event in the same cycle.
module wake_seq_ctrl (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  active_i,
    input  logic                  bus_dom_i,
    input  logic                  ev1_hit_i,
    input  logic                  ev23_hit_i,
    input  logic                  expired_i,
    output logic                  ev1_clr_o,
    output logic                  ev23_clr_o,
    output logic                  ev23_target_o,
    output logic                  tmr_clr_o,
    output logic                  tmr_inc_o,
    output wake_pkg::seq_state_t  state_o,
    output logic                  wake_pulse_o
);
    import wake_pkg::*;

    seq_state_t state_q;
    seq_state_t state_d;
    logic       in_mid;
    logic       accept;

    assign in_mid = (state_q == SEQ_WAIT_REC) || (state_q == SEQ_WAIT_DOM3);

    // Purpose: control of the filters and the window timer.
    always_comb begin
        ev1_clr_o     = !active_i || (state_q != SEQ_IDLE);
        ev23_clr_o    = !active_i || !in_mid || expired_i;
        ev23_target_o = (state_q == SEQ_WAIT_DOM3) ? LVL_DOMINANT : LVL_RECESSIVE;
        tmr_clr_o     = !active_i
                     || (state_q == SEQ_WOKEN)
                     || expired_i
                     || ((state_q == SEQ_IDLE) && (bus_dom_i == LVL_RECESSIVE));
        tmr_inc_o     = !tmr_clr_o;
    end

    assign accept = active_i && (state_q == SEQ_WAIT_DOM3) && !expired_i && ev23_hit_i;

    // Purpose: next sequence state.
    always_comb begin
        state_d = state_q;
        if (!active_i) begin
            state_d = SEQ_IDLE;
        end else begin
            unique case (state_q)
                SEQ_IDLE:      if (ev1_hit_i)  state_d = SEQ_WAIT_REC;
                SEQ_WAIT_REC:  if (expired_i)  state_d = SEQ_IDLE;
                               else if (ev23_hit_i) state_d = SEQ_WAIT_DOM3;
                SEQ_WAIT_DOM3: if (expired_i)  state_d = SEQ_IDLE;
                               else if (ev23_hit_i) state_d = SEQ_WOKEN;
                SEQ_WOKEN:     state_d = SEQ_WOKEN;
                default:       state_d = SEQ_IDLE;
            endcase
        end
    end

    // Purpose: sequence state and acceptance flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= SEQ_IDLE;
            wake_pulse_o <= 1'b0;
        end else begin
            state_q      <= state_d;
            wake_pulse_o <= accept;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/bus_wake_detector.sv
// Top of the bus wake-up pattern detector. Synchronizes the bus level,
// runs the event filters, window timer and sequence controller, and
// drives the receive line: bus-following in normal mode or after an
// accepted wake-up, held high otherwise in standby.
// Assumes: EV1_CYC <= WINDOW_CYC; EV23_CYC >= 1; SYNC_STAGES >= 1.
module bus_wake_detector #(
    parameter int SYNC_STAGES = 2,
    parameter int EV1_CYC     = 100,
    parameter int EV23_CYC    = 20,
    parameter int WINDOW_CYC  = 160000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic standby_i,
    input  logic wake_en_i,
    input  logic bus_dom_i,
    output logic rxd_o,
    output logic wake_pulse_o
);
    import wake_pkg::*;

    logic       bus_s;
    logic       active;
    logic       ev1_clr, ev1_hit;
    logic       ev23_clr, ev23_hit, ev23_target;
    logic       tmr_clr, tmr_inc, expired;
    seq_state_t seq_state;
    logic       follow_bus;
    logic       rxd_q;

    assign active = standby_i && wake_en_i;

    wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (bus_dom_i),
        .q_o   (bus_s)
    );

    wake_run_filter #(.LEN(EV1_CYC)) u_ev1_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (ev1_clr),
        .level_i  (bus_s),
        .target_i (LVL_DOMINANT),
        .hit_o    (ev1_hit)
    );

    wake_run_filter #(.LEN(EV23_CYC)) u_ev23_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (ev23_clr),
        .level_i  (bus_s),
        .target_i (ev23_target),
        .hit_o    (ev23_hit)
    );

    wake_window_timer #(.LIMIT(WINDOW_CYC)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (tmr_clr),
        .inc_i     (tmr_inc),
        .expired_o (expired)
    );

    wake_seq_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .active_i      (active),
        .bus_dom_i     (bus_s),
        .ev1_hit_i     (ev1_hit),
        .ev23_hit_i    (ev23_hit),
        .expired_i     (expired),
        .ev1_clr_o     (ev1_clr),
        .ev23_clr_o    (ev23_clr),
        .ev23_target_o (ev23_target),
        .tmr_clr_o     (tmr_clr),
        .tmr_inc_o     (tmr_inc),
        .state_o       (seq_state),
        .wake_pulse_o  (wake_pulse_o)
    );

    assign follow_bus = !standby_i || (seq_state == SEQ_WOKEN);

    // Purpose: registered receive line, high unless reporting bus state.
    always_ff @(posedge clk) begin
        if (!rst_n)          rxd_q <= 1'b1;
        else if (follow_bus) rxd_q <= (bus_s == LVL_RECESSIVE);
        else                 rxd_q <= 1'b1;
    end

    assign rxd_o = rxd_q;

endmodule

// File: rtl/bus_wake_checker.sv
// Property checker for bus_wake_detector, attached with bind.
// Assumes: synchronous active-low reset held for at least one edge.
module bus_wake_checker (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 standby_i,
    input logic                 wake_en_i,
    input logic                 bus_dom_i,
    input logic                 rxd_o,
    input logic                 wake_pulse_o,
    input wake_pkg::seq_state_t state
);
    import wake_pkg::*;

    AST_NORMAL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(rst_n, 3) && !$past(standby_i))
        |-> (rxd_o == !$past(bus_dom_i, 3)));                          // R1

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(standby_i) && ($past(state) != SEQ_WOKEN))
        |-> rxd_o);                                                     // R2

    AST_PULSE_FROM_DOM3: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse_o |-> ((state == SEQ_WOKEN) && ($past(state) == SEQ_WAIT_DOM3))); // R5

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse_o |=> !wake_pulse_o);                                // R7

    AST_WOKEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(state) == SEQ_WOKEN) && $past(standby_i) && $past(wake_en_i))
        |-> (state == SEQ_WOKEN));                                      // R8

    AST_PULSE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse_o |-> ($past(standby_i) && $past(wake_en_i)));       // R9

    AST_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(standby_i)) |-> (state == SEQ_IDLE));   // R10

endmodule

bind bus_wake_detector bus_wake_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .standby_i    (standby_i),
    .wake_en_i    (wake_en_i),
    .bus_dom_i    (bus_dom_i),
    .rxd_o        (rxd_o),
    .wake_pulse_o (wake_pulse_o),
    .state        (seq_state)
);

// File: tb/tb_bus_wake_detector.sv
// Self-checking bench: table of wake patterns, then directed corner tests.
module tb_bus_wake_detector;

    localparam int CLK_PERIOD = 10;
    localparam int F1  = 4;
    localparam int F2  = 2;
    localparam int WIN = 20;
    localparam int NVEC = 9;

    // {first dominant run, recessive run, second dominant run, wake expected}
    localparam int VEC [NVEC][4] = '{
        '{4, 2, 2, 1},    // R3 R4 R5 minimum lengths
        '{3, 2, 2, 0},    // R3 first run one short
        '{4, 1, 2, 0},    // R4 recessive one short
        '{4, 2, 1, 0},    // R5 last run one short
        '{10, 8, 2, 1},   // R6 completes on last legal sample
        '{10, 9, 2, 0},   // R6 one sample late
        '{20, 2, 3, 0},   // R6 long first run exhausts window
        '{6, 3, 5, 1},    // R7 longer runs still accepted
        '{3, 1, 3, 0}     // R3 glitched first event
    };

    logic clk = 1'b0;
    logic rst_n, standby, wake_en, bus;
    logic rxd, wpulse;
    int   checks = 0;
    int   errors = 0;
    int   pulses = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bus_wake_detector #(
        .SYNC_STAGES (2),
        .EV1_CYC     (F1),
        .EV23_CYC    (F2),
        .WINDOW_CYC  (WIN)
    ) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .standby_i    (standby),
        .wake_en_i    (wake_en),
        .bus_dom_i    (bus),
        .rxd_o        (rxd),
        .wake_pulse_o (wpulse)
    );

    always @(negedge clk) if (wpulse === 1'b1) pulses++;

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_standby();
        standby = 1'b0; bus = 1'b0; step(3);
        standby = 1'b1; step(3);
        pulses = 0;
    endtask

    task automatic pattern(input int d1, input int r2, input int d3);
        bus = 1'b1; step(d1);
        bus = 1'b0; step(r2);
        bus = 1'b1; step(d3);
        bus = 1'b0; step(WIN + 8);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; standby = 1'b1; wake_en = 1'b1; bus = 1'b0;
        step(3);
        check("R10 reset rxd", int'(rxd), 1);
        check("R10 reset pulse", int'(wpulse), 0);
        rst_n = 1'b1;
        step(2);

        // R1: normal mode follows the bus after three cycles
        standby = 1'b0; bus = 1'b0; step(4);
        bus = 1'b1; step(2);
        check("R1 latency not yet", int'(rxd), 1);
        step(1);
        check("R1 dominant seen", int'(rxd), 0);
        bus = 1'b0; step(3);
        check("R1 recessive seen", int'(rxd), 1);

        // Pattern table
        for (int i = 0; i < NVEC; i++) begin
            clear_standby();
            pattern(VEC[i][0], VEC[i][1], VEC[i][2]);
            check($sformatf("R6 R7 vector %0d pulses", i), pulses, VEC[i][3]);
            bus = 1'b1; step(3);
            check($sformatf("R8 R2 vector %0d rxd", i), int'(rxd), VEC[i][3] ? 0 : 1);
        end

        // R11: stuck dominant, then recovery and a valid request
        clear_standby();
        bus = 1'b1; step(150);
        check("R11 stuck dominant pulses", pulses, 0);
        check("R11 stuck dominant rxd", int'(rxd), 1);
        bus = 1'b0; step(WIN + 5);
        pattern(F1, F2, F2);
        check("R6 restart after expiry", pulses, 1);

        // R9: feature disabled
        wake_en = 1'b0;
        clear_standby();
        pattern(6, 3, 5);
        check("R9 disabled pulses", pulses, 0);
        bus = 1'b1; step(3);
        check("R9 disabled rxd", int'(rxd), 1);
        wake_en = 1'b1;

        // R10: leaving standby drops the woken state
        clear_standby();
        pattern(F1, F2, F2);
        bus = 1'b1; step(3);
        check("R8 woken rxd low", int'(rxd), 0);
        bus = 1'b0; step(3);
        check("R8 woken rxd high", int'(rxd), 1);
        standby = 1'b0; step(1);
        standby = 1'b1; bus = 1'b1; step(3);
        check("R10 standby exit clears", int'(rxd), 1);

        // R10: reset drops the woken state
        clear_standby();
        pattern(F1, F2, F2);
        check("R7 single pulse", pulses, 1);
        rst_n = 1'b0; step(1);
        rst_n = 1'b1; bus = 1'b1; step(3);
        check("R10 reset clears woken", int'(rxd), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule